// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a small 32-bit register bus. A 16-bit counter counts up once per prescaled tick. It times out when it wraps past 0xFFFF, so software sets a timeout of N ticks by loading 65536 − N. Software services the watchdog by loading the counter again before it wraps. A timeout sets a sticky overflow flag and drives a reset request for one clock. The counter then goes on counting from zero.

Every write must carry a key in its upper bits, and the key depends on the register. A write with a wrong key is dropped without a trace. A counter write is not complete at once: a busy flag stays set for a few clocks afterwards. Software must wait for that flag to clear before it sets the enable bit. The live count can be read back, so software can work out the time left as 65536 minus the count.

Address map, byte offsets on `addr_i`:

| Offset | Contents |
|--------|----------|
| 0x0 | counter; the read data is the count in bits [15:0] |
| 0x4 | control/status: bit 7 enable, bit 5 busy (read-only), bit 4 overflow, bits [2:0] divider select; all other bits read 0 |
| 0x8 | reserved; reads 0 |

A write is taken on a rising clock edge when `we_i` is high. Reads are combinational on `addr_i`.

Top module: `kwdt_top`

## Requirements
- R1: After reset, and while `rst_ni` is low, the counter reads 0, offset 0x4 reads 0 and `reset_req_o` is low.
- R2: A write to offset 0x0 loads `wdata_i[15:0]` into the counter only if `wdata_i[31:16]` is 0x5A5A and busy is clear. An accepted load overrides any count in that cycle, and a load while running restarts the timeout. Any other counter write changes nothing.
- R3: A write to offset 0x4 takes effect only if `wdata_i[31:8]` is 0xA5A5A5. It sets enable from bit 7 and the divider select from bits [2:0]. Bits 6 and 5 of the written data are ignored, and every other read bit of offset 0x4 stays 0. A write with a wrong key changes nothing.
- R4: An accepted counter write sets busy (offset 0x4 bit 5) for exactly 3 clocks, starting with the clock after the write edge. Counter writes that arrive while busy is set are ignored.
- R5: While enabled, the counter advances by one every D clocks. D is chosen by select values 0..7 and is 1, 4, 16, 32, 64, 128, 1024 or 4096.
- R6: The prescaler restarts its phase from zero on two events: the write that sets enable from 0 to 1, and a write that changes the divider select.
- R7: When the counter is advanced from 0xFFFF, it becomes 0 and the overflow flag (offset 0x4 bit 4) is set. `reset_req_o` is then high for exactly one clock, and the counter keeps counting.
- R8: A keyed write to offset 0x4 with bit 4 at 0 clears the overflow flag. Writing bit 4 as 1 leaves the flag as it is.
- R9: While enable is clear, the counter holds its value except for an accepted load.
- R10: Offset 0x8 always reads 0, and a write to it, even with a correct key, has no effect on any state.
- R11: A read of offset 0x0 returns the live count in bits [15:0] and 0 in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | peripheral clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| we_i | input | 1 | write strobe, sampled on the rising edge |
| addr_i | input | 4 | byte offset of the register |
| wdata_i | input | 32 | write data including key bits |
| rdata_o | output | 32 | read data for `addr_i` |
| reset_req_o | output | 1 | one-clock reset request on timeout |

## Verification
The hardest case to reach from the ports is a change of the divider select in the middle of a prescaler phase. Without the restart, the next tick would come early but would still look plausible. The bench first lets a divide-by-4 run through one full tick and one more clock. It then switches to divide-by-16. The count must stay unchanged for 15 clocks after that write and step on the 16th. The overflow case is set up by loading the counter just below the wrap point at divide-by-1. This places the one-clock reset request on a known cycle. A counter write that arrives while busy is set is timed from the table, so that it falls exactly on the last busy clock.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PRE_W   = 12;
  localparam logic [15:0] KEY_CNT = 16'h5A5A;
  localparam logic [23:0] KEY_CTL = 24'hA5A5A5;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_BUSY = 5;
  localparam int unsigned BIT_OVF  = 4;

  typedef struct packed {
    logic       en;
    logic       ovf;
    logic [2:0] sel;
  } ctl_t;

  // divide ratio minus one for each select value
  function automatic logic [PRE_W-1:0] div_last(input logic [2:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      3'd0:    r = PRE_W'(0);
      3'd1:    r = PRE_W'(3);
      3'd2:    r = PRE_W'(15);
      3'd3:    r = PRE_W'(31);
      3'd4:    r = PRE_W'(63);
      3'd5:    r = PRE_W'(127);
      3'd6:    r = PRE_W'(1023);
      default: r = PRE_W'(4095);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/kwdt_regif.sv
module kwdt_regif
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  ctl_t              ctl_i,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              ctl_wr_o,
  output logic [7:0]        ctl_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(4);

  logic key_cnt_ok, key_ctl_ok;

  assign key_cnt_ok  = (wdata_i[31:16] == KEY_CNT);
  assign key_ctl_ok  = (wdata_i[31:8]  == KEY_CTL);

  // busy blocks further counter loads until the previous one has settled
  assign cnt_wr_o    = we_i && (addr_i == OFF_CNT) && key_cnt_ok && !busy_i;
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];
  assign ctl_wr_o    = we_i && (addr_i == OFF_CTL) && key_ctl_ok;
  assign ctl_wdata_o = wdata_i[7:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_CNT) begin
      rdata_o[CNT_W-1:0] = cnt_i;
    end else if (addr_i == OFF_CTL) begin
      rdata_o[BIT_EN]   = ctl_i.en;
      rdata_o[BIT_BUSY] = busy_i;
      rdata_o[BIT_OVF]  = ctl_i.ovf;
      rdata_o[2:0]      = ctl_i.sel;
    end
  end
endmodule

// File: rtl/kwdt_csr.sv
module kwdt_csr
  import kwdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       ovf_set_i,
  output ctl_t       ctl_o,
  output logic       restart_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (wr_i) begin
        ctl_q.en  <= wdata_i[BIT_EN];
        ctl_q.sel <= wdata_i[2:0];
        if (!wdata_i[BIT_OVF]) ctl_q.ovf <= 1'b0;
      end
      // a new overflow wins over a clear in the same cycle
      if (ovf_set_i) ctl_q.ovf <= 1'b1;
    end
  end

  assign restart_o = wr_i && ((wdata_i[BIT_EN] && !ctl_q.en) || (wdata_i[2:0] != ctl_q.sel));
  assign ctl_o     = ctl_q;
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  input  logic       restart_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;

  assign tick_o = en_i && (pre_q == div_last(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!en_i || restart_i) pre_q <= '0;
    else if (tick_o)            pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned BUSY_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             wrap_o
);
  localparam int unsigned BW = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    busy_q;

  // a load in the same cycle as the last tick suppresses the timeout
  assign wrap_o = tick_i && (&cnt_q) && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_q <= '0;
    else if (wr_i)         busy_q <= BW'(BUSY_CYC);
    else if (busy_q != '0) busy_q <= busy_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (busy_q != '0);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned BUSY_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reset_req_o
);
  logic             cnt_wr, ctl_wr, restart, tick, wrap, busy, req_q;
  logic [CNT_W-1:0] cnt_wdata, cnt_q;
  logic [7:0]       ctl_wdata;
  ctl_t             ctl_q;

  kwdt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .busy_i      (busy),
    .cnt_i       (cnt_q),
    .ctl_i       (ctl_q),
    .cnt_wr_o    (cnt_wr),
    .cnt_wdata_o (cnt_wdata),
    .ctl_wr_o    (ctl_wr),
    .ctl_wdata_o (ctl_wdata),
    .rdata_o     (rdata_o)
  );

  kwdt_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctl_wr),
    .wdata_i   (ctl_wdata),
    .ovf_set_i (wrap),
    .ctl_o     (ctl_q),
    .restart_o (restart)
  );

  kwdt_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctl_q.en),
    .sel_i     (ctl_q.sel),
    .restart_i (restart),
    .tick_o    (tick)
  );

  kwdt_counter #(.CNT_W(CNT_W), .BUSY_CYC(BUSY_CYC)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cnt_wr),
    .wdata_i (cnt_wdata),
    .tick_i  (tick),
    .cnt_o   (cnt_q),
    .busy_o  (busy),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= wrap;
  end

  assign reset_req_o = req_q;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              reset_req_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              en_q,
  input logic              ovf_q,
  input logic              busy_q
);
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o); // R7
  AST_REQ_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> ovf_q); // R7
  AST_REQ_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (cnt_q == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !(we_i && addr_i == '0)) |=> $stable(cnt_q)); // R9
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(busy_q, 3)); // R4
  AST_BUSY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !en_q) |=> $stable(cnt_q)); // R4
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(8)) |-> (rdata_o == 32'h0)); // R10
  AST_CTL_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(4)) |-> (rdata_o[31:8] == 24'h0 && !rdata_o[6] && !rdata_o[3])); // R3
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .reset_req_o (reset_req_o),
  .cnt_q       (cnt_q),
  .en_q        (ctl_q.en),
  .ovf_q       (ctl_q.ovf),
  .busy_q      (busy)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        reset_req_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  kwdt_top u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .reset_req_o (reset_req_o)
  );

  // {is_write, addr, data, expected}
  localparam int NV = 16;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'h4, 32'h0,        32'h0},        // R1 status after reset
    {1'b0, 4'h0, 32'h0,        32'h0},        // R1 counter after reset
    {1'b1, 4'h0, 32'h12341111, 32'h0},        // R2 wrong key
    {1'b0, 4'h0, 32'h0,        32'h0},        // R2 unchanged
    {1'b1, 4'h0, 32'h5A5A1234, 32'h0},        // R2 good load
    {1'b0, 4'h0, 32'h0,        32'h00001234}, // R11 live count
    {1'b0, 4'h4, 32'h0,        32'h00000020}, // R4 busy visible
    {1'b1, 4'h0, 32'h5A5A9999, 32'h0},        // R4 load on last busy clock
    {1'b0, 4'h0, 32'h0,        32'h00001234}, // R4 ignored
    {1'b0, 4'h4, 32'h0,        32'h0},        // R4 busy gone
    {1'b1, 4'h4, 32'h000000FF, 32'h0},        // R3 wrong key
    {1'b0, 4'h4, 32'h0,        32'h0},        // R3 unchanged
    {1'b1, 4'h4, 32'hA5A5A563, 32'h0},        // R3 bits 6,5 ignored
    {1'b0, 4'h4, 32'h0,        32'h00000003}, // R3 select only
    {1'b1, 4'h8, 32'hA5A5A5FF, 32'h0},        // R10 reserved write
    {1'b0, 4'h8, 32'h0,        32'h0}         // R10 reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk_i);
    chk("R1 reset_req low", {31'b0, reset_req_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) begin
        wr(VEC[i][67:64], VEC[i][63:32]);
      end else begin
        rd(VEC[i][67:64], v);
        chk($sformatf("R%0d vec%0d", (i < 2) ? 1 : (i < 5) ? 2 : (i == 5) ? 11 : (i < 10) ? 4 : (i < 14) ? 3 : 10, i), v, VEC[i][31:0]);
        @(negedge clk_i);
      end
    end
    rd(4'h4, v); chk("R10 status untouched", v, 32'h3);

    // R7 overflow at divide-by-1
    wr(4'h0, 32'h5A5AFFFD);
    repeat (4) @(negedge clk_i);
    wr(4'h4, 32'hA5A5A580);
    repeat (2) @(negedge clk_i);
    rd(4'h0, v); chk("R7 pre-wrap count", v, 32'h0000FFFF);
    chk("R7 no early request", {31'b0, reset_req_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 request high", {31'b0, reset_req_o}, 32'h1);
    rd(4'h0, v); chk("R7 wrapped to zero", v, 32'h0);
    rd(4'h4, v); chk("R7 overflow flag", v, 32'h90);
    @(negedge clk_i);
    chk("R7 request one clock", {31'b0, reset_req_o}, 32'h0);
    rd(4'h0, v); chk("R7 keeps counting", v, 32'h1);

    // R8 flag clear and write-one no effect
    wr(4'h4, 32'hA5A5A580);
    rd(4'h4, v); chk("R8 cleared", v, 32'h80);
    wr(4'h4, 32'hA5A5A590);
    rd(4'h4, v); chk("R8 write one keeps clear", v, 32'h80);

    // R9 disable freezes
    wr(4'h4, 32'hA5A5A500);
    rd(4'h0, v);
    repeat (10) @(negedge clk_i);
    rd(4'h0, v2); chk("R9 frozen count", v2, v);

    // R5/R6 divide-by-4 then switch to 16 mid-phase
    wr(4'h0, 32'h5A5A0000);
    repeat (4) @(negedge clk_i);
    wr(4'h4, 32'hA5A5A581);
    repeat (3) @(negedge clk_i);
    rd(4'h0, v); chk("R6 phase from enable", v, 32'h0);
    @(negedge clk_i);
    rd(4'h0, v); chk("R5 divide by 4", v, 32'h1);
    @(negedge clk_i);
    wr(4'h4, 32'hA5A5A582);
    repeat (15) @(negedge clk_i);
    rd(4'h0, v); chk("R6 restart on select change", v, 32'h1);
    @(negedge clk_i);
    rd(4'h0, v); chk("R5 divide by 16", v, 32'h2);

    // R5 slowest divider
    wr(4'h4, 32'hA5A5A500);
    wr(4'h0, 32'h5A5A0010);
    repeat (4) @(negedge clk_i);
    wr(4'h4, 32'hA5A5A587);
    repeat (4095) @(negedge clk_i);
    rd(4'h0, v); chk("R5 divide 4096 hold", v, 32'h10);
    @(negedge clk_i);
    rd(4'h0, v); chk("R5 divide 4096 step", v, 32'h11);

    // R2 service while running
    wr(4'h0, 32'h5A5A0100);
    rd(4'h0, v); chk("R2 reload while running", v, 32'h100);

    // R1 reset in mid-run
    rst_ni = 1'b0;
    #1;
    rd(4'h0, v); chk("R1 counter cleared", v, 32'h0);
    rd(4'h4, v); chk("R1 status cleared", v, 32'h0);
    chk("R1 request low", {31'b0, reset_req_o}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule